// File: doc/BRIEF.md
# Amplifier Fault and Mute Supervisor

This block supervises the protection inputs of a switching audio power stage and decides when the gate controller must turn every output transistor off. It watches the two PWM inputs that are used in bridged (two-channel) mode for loss of switching activity. It compares an 8-bit die-temperature code against a warning threshold, a shutdown threshold and a common release threshold, which gives hysteresis. It latches any per-transistor overcurrent comparator hit until the mute input is taken through a full assert-and-release cycle, or until reset.

Each fault class is a small enumerated state machine with its own clearing rule. The link watcher has the states `LW_OFF` (four-channel mode, detection inactive), `LW_WATCH` (counting idle cycles) and `LW_LOST` (timeout reached). Its transitions are OFF→WATCH when bridged mode is selected, WATCH→LOST when the idle count reaches the limit, LOST→WATCH on any input edge, and any state→OFF when four-channel mode is selected. The thermal guard has the states `TH_NORMAL`, `TH_WARN` and `TH_SHUT`. Its transitions are NORMAL→WARN above the warning level, NORMAL/WARN→SHUT above the shutdown level, and WARN/SHUT→NORMAL below the release level. The overcurrent latch has the states `OC_CLEAR`, `OC_TRIPPED` and `OC_MUTE_HELD`. Its transitions are CLEAR→TRIPPED on any comparator hit, TRIPPED→MUTE_HELD while the synchronized mute is high, and MUTE_HELD→CLEAR on mute release, or MUTE_HELD→TRIPPED on release if a hit is still present.

The force-off output is combinational from the synchronized mute and the registered fault flags. The mute pin passes through a two-flop synchronizer before use.

Top module: `amp_fault_supervisor`

## Requirements
- R1: After reset, with mute low and no comparator hit, data_loss, therm_warn, therm_shut, oc_flag and force_off are all 0.
- R2: With bridged_mode = 1, data_loss rises once neither pwm_a nor pwm_c has changed level for LOSS_CYCLES clock cycles (plus the input synchronizer latency), and it falls within a few cycles of the next edge on either input.
- R3: With bridged_mode = 0, data_loss stays 0 however long the PWM inputs stay idle, and it has no effect on force_off.
- R4: therm_warn sets when die_temp is strictly greater than WARN_C (default 135). A code equal to WARN_C does not set it.
- R5: therm_shut sets when die_temp is strictly greater than SHUT_C (default 150), and therm_warn is always 1 while therm_shut is 1.
- R6: Once set, therm_warn and therm_shut both stay set until die_temp is strictly less than CLEAR_C (default 120). Both then clear together.
- R7: Any 1 bit on oc_hit sets oc_flag on the next clock, and oc_flag stays 1 after every bit returns to 0.
- R8: oc_flag clears only after the synchronized mute has been seen high and then low with no hit present, or on reset.
- R9: force_off is 1 exactly when the synchronized mute, therm_shut, oc_flag or data_loss (bridged mode only) is 1.
- R10: mute reaches force_off through two flip-flops. After mute rises, force_off is still 0 after the first clock edge and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridged_mode | input | 1 | Latched channel mode: 1 = two-channel bridged, 0 = four-channel |
| pwm_a | input | 1 | PWM input of bridge A |
| pwm_c | input | 1 | PWM input of bridge C |
| die_temp | input | TEMP_W | Unsigned die temperature code, degrees C |
| oc_hit | input | NUM_SW | One overcurrent comparator bit per power transistor |
| mute | input | 1 | Asynchronous mute request, active high |
| data_loss | output | 1 | Bridged-mode PWM inactivity flag |
| therm_warn | output | 1 | Thermal warning flag |
| therm_shut | output | 1 | Thermal shutdown flag |
| oc_flag | output | 1 | Latched overcurrent flag |
| force_off | output | 1 | Turn all output transistors off |

## Verification
The hardest situation to reach from the ports is the overcurrent latch leaving `OC_MUTE_HELD`. Mute must stay high long enough to cross the synchronizer, and the release must come while the comparator bits are low, or the latch re-trips. The stimulus table holds each vector for several cycles so that every mute change settles. It walks trip, hold, mute-high, mute-release in sequence and repeats the sequence with a different transistor bit. Thermal hysteresis is reached by ramping the code up past both thresholds and back down through the exact boundary codes 150, 135 and 120.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

    typedef enum logic [1:0] {
        LW_OFF   = 2'd0,
        LW_WATCH = 2'd1,
        LW_LOST  = 2'd2
    } link_state_t;

    typedef enum logic [1:0] {
        TH_NORMAL = 2'd0,
        TH_WARN   = 2'd1,
        TH_SHUT   = 2'd2
    } therm_state_t;

    typedef enum logic [1:0] {
        OC_CLEAR     = 2'd0,
        OC_TRIPPED   = 2'd1,
        OC_MUTE_HELD = 2'd2
    } oc_state_t;

endpackage

// File: rtl/amp_link_watch.sv
module amp_link_watch
    import amp_sup_pkg::*;
#(
    parameter int unsigned LOSS_CYCLES = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bridged_mode,
    input  logic pwm_a,
    input  logic pwm_c,
    output logic data_loss
);
    localparam int unsigned CNT_W = $clog2(LOSS_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOSS_CYCLES - 1);

    logic [1:0]       a_sync, c_sync;
    logic             a_prev, c_prev;
    logic             edge_seen;
    logic [CNT_W-1:0] idle_cnt;
    link_state_t      state, state_nx;

    // input synchronizers and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sync <= '0;
            c_sync <= '0;
            a_prev <= 1'b0;
            c_prev <= 1'b0;
        end else begin
            a_sync <= {a_sync[0], pwm_a};
            c_sync <= {c_sync[0], pwm_c};
            a_prev <= a_sync[1];
            c_prev <= c_sync[1];
        end
    end

    assign edge_seen = (a_sync[1] ^ a_prev) | (c_sync[1] ^ c_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LW_OFF;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LW_OFF:   if (bridged_mode) state_nx = LW_WATCH;
            LW_WATCH: if (!bridged_mode) state_nx = LW_OFF;
                      else if (!edge_seen && idle_cnt == LAST_CNT) state_nx = LW_LOST;
            LW_LOST:  if (!bridged_mode) state_nx = LW_OFF;
                      else if (edge_seen) state_nx = LW_WATCH;
            default:  state_nx = LW_OFF;
        endcase
    end

    // idle counter: reloads on every edge, runs only while watching
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   idle_cnt <= '0;
        else if (state != LW_WATCH || edge_seen)      idle_cnt <= '0;
        else if (idle_cnt != LAST_CNT)                idle_cnt <= idle_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        data_loss = (state == LW_LOST);
    end

    AST_LOSS_OFF_IN_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        !bridged_mode |=> !data_loss) else $error("loss flag in four-channel mode"); // R3
    AST_LOSS_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_loss && edge_seen) |=> !data_loss) else $error("loss flag kept after edge"); // R2

endmodule

// File: rtl/amp_thermal_guard.sv
module amp_thermal_guard
    import amp_sup_pkg::*;
#(
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned WARN_C  = 135,
    parameter int unsigned SHUT_C  = 150,
    parameter int unsigned CLEAR_C = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] die_temp,
    output logic              therm_warn,
    output logic              therm_shut
);
    localparam logic [TEMP_W-1:0] WARN_LVL  = TEMP_W'(WARN_C);
    localparam logic [TEMP_W-1:0] SHUT_LVL  = TEMP_W'(SHUT_C);
    localparam logic [TEMP_W-1:0] CLEAR_LVL = TEMP_W'(CLEAR_C);

    therm_state_t state, state_nx;
    logic hot_warn, hot_shut, cooled;

    assign hot_warn = die_temp > WARN_LVL;
    assign hot_shut = die_temp > SHUT_LVL;
    assign cooled   = die_temp < CLEAR_LVL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TH_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TH_NORMAL: if (hot_shut) state_nx = TH_SHUT;
                       else if (hot_warn) state_nx = TH_WARN;
            TH_WARN:   if (hot_shut) state_nx = TH_SHUT;
                       else if (cooled) state_nx = TH_NORMAL;
            TH_SHUT:   if (cooled) state_nx = TH_NORMAL;
            default:   state_nx = TH_NORMAL;
        endcase
    end

    always_comb begin
        therm_warn = (state != TH_NORMAL);
        therm_shut = (state == TH_SHUT);
    end

    AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_shut && !cooled) |=> therm_shut) else $error("shutdown released early"); // R6
    AST_WARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_warn && !cooled) |=> therm_warn) else $error("warning released early"); // R6
    AST_SHUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hot_shut |=> therm_shut) else $error("shutdown missed"); // R5

endmodule

// File: rtl/amp_oc_latch.sv
module amp_oc_latch
    import amp_sup_pkg::*;
#(
    parameter int unsigned NUM_SW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] oc_hit,
    input  logic              mute_sync,
    output logic              oc_flag
);
    oc_state_t state, state_nx;
    logic      any_hit;

    assign any_hit = |oc_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OC_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OC_CLEAR:     if (any_hit) state_nx = OC_TRIPPED;
            OC_TRIPPED:   if (mute_sync) state_nx = OC_MUTE_HELD;
            OC_MUTE_HELD: if (!mute_sync) state_nx = any_hit ? OC_TRIPPED : OC_CLEAR;
            default:      state_nx = OC_CLEAR;
        endcase
    end

    always_comb begin
        oc_flag = (state != OC_CLEAR);
    end

    AST_OC_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> oc_flag) else $error("overcurrent not latched"); // R7
    AST_OC_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && !mute_sync && !$past(mute_sync)) |=> oc_flag) else $error("overcurrent cleared without mute"); // R8

endmodule

// File: rtl/amp_fault_supervisor.sv
module amp_fault_supervisor
    import amp_sup_pkg::*;
#(
    parameter int unsigned LOSS_CYCLES = 6_250_000,
    parameter int unsigned TEMP_W      = 8,
    parameter int unsigned WARN_C      = 135,
    parameter int unsigned SHUT_C      = 150,
    parameter int unsigned CLEAR_C     = 120,
    parameter int unsigned NUM_SW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bridged_mode,
    input  logic              pwm_a,
    input  logic              pwm_c,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [NUM_SW-1:0] oc_hit,
    input  logic              mute,
    output logic              data_loss,
    output logic              therm_warn,
    output logic              therm_shut,
    output logic              oc_flag,
    output logic              force_off
);
    localparam int unsigned SYNC_STAGES = 2;

    logic [SYNC_STAGES-1:0] mute_pipe;
    logic                   mute_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mute_pipe <= '0;
        else        mute_pipe <= {mute_pipe[SYNC_STAGES-2:0], mute};
    end
    assign mute_sync = mute_pipe[SYNC_STAGES-1];

    amp_link_watch #(.LOSS_CYCLES(LOSS_CYCLES)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .bridged_mode (bridged_mode),
        .pwm_a        (pwm_a),
        .pwm_c        (pwm_c),
        .data_loss    (data_loss)
    );

    amp_thermal_guard #(
        .TEMP_W  (TEMP_W),
        .WARN_C  (WARN_C),
        .SHUT_C  (SHUT_C),
        .CLEAR_C (CLEAR_C)
    ) u_therm (
        .clk        (clk),
        .rst_n      (rst_n),
        .die_temp   (die_temp),
        .therm_warn (therm_warn),
        .therm_shut (therm_shut)
    );

    amp_oc_latch #(.NUM_SW(NUM_SW)) u_oc (
        .clk       (clk),
        .rst_n     (rst_n),
        .oc_hit    (oc_hit),
        .mute_sync (mute_sync),
        .oc_flag   (oc_flag)
    );

    always_comb begin
        force_off = mute_sync | therm_shut | oc_flag | (bridged_mode & data_loss);
    end

    AST_SHUT_IMPLIES_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        therm_shut |-> therm_warn) else $error("shutdown without warning"); // R5
    AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_shut || oc_flag) |-> force_off) else $error("fault not forcing off"); // R9
    AST_MUTE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mute_pipe[0]) |-> force_off) else $error("mute not forcing off"); // R10

endmodule

// File: tb/tb_amp_fault_supervisor.sv
`timescale 1ns/1ps
module tb_amp_fault_supervisor;
    localparam int unsigned LOSS = 40;
    localparam int unsigned NSW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bridged_mode = 1'b0;
    logic pwm_a = 1'b0, pwm_c = 1'b0;
    logic [7:0] die_temp = 8'd25;
    logic [NSW-1:0] oc_hit = '0;
    logic mute = 1'b0;
    logic data_loss, therm_warn, therm_shut, oc_flag, force_off;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    amp_fault_supervisor #(.LOSS_CYCLES(LOSS)) dut (
        .clk(clk), .rst_n(rst_n), .bridged_mode(bridged_mode),
        .pwm_a(pwm_a), .pwm_c(pwm_c), .die_temp(die_temp), .oc_hit(oc_hit),
        .mute(mute), .data_loss(data_loss), .therm_warn(therm_warn),
        .therm_shut(therm_shut), .oc_flag(oc_flag), .force_off(force_off)
    );

    // vector: {temp[20:13], oc[12:5], mute[4], warn, shut, oc_flag, force}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {8'd25,  8'h00, 1'b0, 4'b0000},  // R1 idle
        {8'd136, 8'h00, 1'b0, 4'b1000},  // R4 above warn
        {8'd135, 8'h00, 1'b0, 4'b1000},  // R6 hold
        {8'd151, 8'h00, 1'b0, 4'b1101},  // R5 shutdown
        {8'd140, 8'h00, 1'b0, 4'b1101},  // R6 hold
        {8'd120, 8'h00, 1'b0, 4'b1101},  // R6 boundary hold
        {8'd119, 8'h00, 1'b0, 4'b0000},  // R6 release
        {8'd150, 8'h00, 1'b0, 4'b1000},  // R5 equal code no shutdown
        {8'd100, 8'h00, 1'b0, 4'b0000},  // R6 release from warn
        {8'd25,  8'h04, 1'b0, 4'b0011},  // R7 trip
        {8'd25,  8'h00, 1'b0, 4'b0011},  // R7 latched
        {8'd25,  8'h00, 1'b1, 4'b0011},  // R8 mute held
        {8'd25,  8'h00, 1'b0, 4'b0000},  // R8 release clears
        {8'd25,  8'h80, 1'b0, 4'b0011},  // R7 other switch
        {8'd25,  8'h00, 1'b1, 4'b0011},  // R8 mute held
        {8'd25,  8'h00, 1'b0, 4'b0000},  // R8 release clears
        {8'd25,  8'h00, 1'b1, 4'b0001},  // R9 mute alone
        {8'd25,  8'h00, 1'b0, 4'b0000}   // R9 mute off
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 data_loss", data_loss, 0);
        check("R1 therm_warn", therm_warn, 0);
        check("R1 therm_shut", therm_shut, 0);
        check("R1 oc_flag", oc_flag, 0);
        check("R1 force_off", force_off, 0);

        // R10: synchronizer latency of mute
        mute = 1'b1;
        @(posedge clk); #1;
        check("R10 after one edge", force_off, 0);
        @(posedge clk); #1;
        check("R10 after two edges", force_off, 1);
        mute = 1'b0;
        wait_cyc(4);

        // table walk, four-channel mode so data loss stays out
        for (int i = 0; i < NV; i++) begin
            die_temp = VEC[i][20:13];
            oc_hit   = VEC[i][12:5];
            mute     = VEC[i][4];
            wait_cyc(5);
            check($sformatf("R4/R5/R6 warn vec%0d", i), therm_warn, VEC[i][3]);
            check($sformatf("R5/R6 shut vec%0d", i), therm_shut, VEC[i][2]);
            check($sformatf("R7/R8 oc vec%0d", i), oc_flag, VEC[i][1]);
            check($sformatf("R9 force vec%0d", i), force_off, VEC[i][0]);
        end

        // R8: reset clears the latch
        oc_hit = 8'h01;
        wait_cyc(1);
        oc_hit = '0;
        wait_cyc(3);
        check("R7 latched before reset", oc_flag, 1);
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R8 reset clears", oc_flag, 0);
        check("R8 force after reset", force_off, 0);

        // R2: bridged mode with activity, then idle
        bridged_mode = 1'b1;
        for (int k = 0; k < 10; k++) begin
            pwm_a = ~pwm_a;
            wait_cyc(10);
        end
        check("R2 active no loss", data_loss, 0);
        wait_cyc(20);
        check("R2 short idle no loss", data_loss, 0);
        wait_cyc(40);
        check("R2 long idle loss", data_loss, 1);
        check("R9 loss forces off", force_off, 1);
        pwm_c = ~pwm_c;
        wait_cyc(6);
        check("R2 edge clears loss", data_loss, 0);
        check("R9 force released", force_off, 0);
        wait_cyc(70);
        check("R2 second timeout", data_loss, 1);

        // R3: four-channel mode ignores idle inputs
        bridged_mode = 1'b0;
        wait_cyc(2);
        check("R3 loss dropped", data_loss, 0);
        wait_cyc(120);
        check("R3 long idle no loss", data_loss, 0);
        check("R3 no force", force_off, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule